// File: doc/BRIEF.md
# Microcoded Block Copy Engine

This block copies a run of consecutive words from one place in a word-organised memory to another. A small microprogram drives the copy, not a hard-wired state machine. A start strobe carries three register indices. The first names a register that holds the source byte address. The second names a register that holds the destination byte address. The third names a register that holds the number of words to move. The engine runs its microcode loop until the count is used up, and then raises a one-cycle done pulse.

The datapath holds a register file, one adder/subtractor, an ALUOut staging register and a memory data register (MDR). A value that moves between registers, or from a register to memory, passes through ALUOut, and each such move costs one clock. The microcode tests ALUOut for zero to leave the loop. Register 8 is the scratch register that holds the word in transit. After the copy, the source and destination registers have moved forward by four bytes per word, and the count register holds zero. The register file is loaded and read through a side port while the engine is idle.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_re` and `mem_we` are low and every register reads zero. While `busy` is low, no memory access is made and `done` stays low.
- R2: With count n, `done` is high in the cycle that follows the (2+7n)-th rising edge after the edge that accepted `start`.
- R3: The loop exit is decided by ALUOut being zero. A count of zero makes no memory read or write. A nonzero ALUOut at a loop test continues the copy with a memory read in the next cycle.
- R4: After the copy, destination word k holds the value that source word k had at the moment it was read, for k in increasing order from 0 to n-1. Word index is byte address bits [9:2]. No other memory word changes.
- R5: At the end, the source register holds src+4n and the destination register holds dst+4n, with both addresses in bytes. The count register holds 0. For n>0 register 8 holds the last word copied. For n=0 register 8 is unchanged.
- R6: Each word costs exactly one read and one write. Reads and writes are never asserted together, and a read is never followed directly by a write. Write addresses run dst, dst+4, and so on.
- R7: `done` lasts exactly one cycle, and in the next cycle `busy` is low.
- R8: `start` is accepted only while `busy` is low, and the engine then goes busy. A `start` or a side-port register write while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy (taken when idle) |
| rs_idx | input | 5 | Index of the source-address register |
| rd_idx | input | 5 | Index of the destination-address register |
| rt_idx | input | 5 | Index of the word-count register |
| busy | output | 1 | Microprogram is running |
| done | output | 1 | One-cycle completion pulse |
| ext_we | input | 1 | Side-port register write (idle only) |
| ext_idx | input | 5 | Side-port register index |
| ext_wdata | input | 32 | Side-port write data |
| ext_rdata | output | 32 | Side-port read data (combinational) |
| mem_re | output | 1 | Memory read request; data is expected next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Registered memory read data |

## Verification
The assertions check several properties on every cycle. Reads and writes never overlap, and a read is never followed directly by a write. The done pulse is one cycle long and returns the engine to idle. The memory stays quiet while the engine is idle. An accepted start makes the engine busy. A zero ALUOut at a loop test leads straight to done, and a nonzero one leads to a memory read. Only the bench scenarios can show the data results. These are the copied contents, including forward-overlapping blocks; the final pointer, count and scratch register values; the exact 2+7n cycle count; and the fact that a start or a register write during a copy is ignored.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  localparam int UPC_W = 4;

  typedef enum logic [1:0] {SEL_RS, SEL_RD, SEL_RT, SEL_TMP} reg_sel_e;
  typedef enum logic [1:0] {WB_NONE, WB_ALU, WB_MDR} wb_e;
  typedef enum logic [2:0] {SQ_NEXT, SQ_JMP, SQ_BZ, SQ_BNZ, SQ_WAIT} seq_e;
  typedef enum logic {ALU_ADD, ALU_SUB} alu_e;

  typedef struct packed {
    alu_e             op;
    reg_sel_e         src1;
    logic [4:0]       imm;
    logic             ld_alu;
    wb_e              wb;
    reg_sel_e         dst;
    logic             mrd;
    logic             mwr;
    logic             ld_mdr;
    logic             fin;
    seq_e             seq;
    logic [UPC_W-1:0] tgt;
  } uword_t;

  localparam logic [UPC_W-1:0] U_IDLE = 4'd0;
  localparam logic [UPC_W-1:0] U_CNT  = 4'd1;
  localparam logic [UPC_W-1:0] U_CHK  = 4'd2;
  localparam logic [UPC_W-1:0] U_RD   = 4'd3;
  localparam logic [UPC_W-1:0] U_CAP  = 4'd4;
  localparam logic [UPC_W-1:0] U_SAV  = 4'd5;
  localparam logic [UPC_W-1:0] U_WR   = 4'd6;
  localparam logic [UPC_W-1:0] U_US   = 4'd7;
  localparam logic [UPC_W-1:0] U_UD   = 4'd8;
  localparam logic [UPC_W-1:0] U_UC   = 4'd9;
  localparam logic [UPC_W-1:0] U_DONE = 4'd10;
endpackage

// File: rtl/bcp_ucode_rom.sv
module bcp_ucode_rom
  import bcp_pkg::*;
(
  input  logic [UPC_W-1:0] upc,
  output uword_t           uw
);
  function automatic uword_t mk(alu_e op, reg_sel_e s1, logic [4:0] imm, logic ld,
                                wb_e wb, reg_sel_e dst, logic mrd, logic mwr,
                                logic ldm, logic fin, seq_e sq, logic [UPC_W-1:0] tgt);
    uword_t w;
    w.op = op; w.src1 = s1; w.imm = imm; w.ld_alu = ld;
    w.wb = wb; w.dst = dst; w.mrd = mrd; w.mwr = mwr;
    w.ld_mdr = ldm; w.fin = fin; w.seq = sq; w.tgt = tgt;
    return w;
  endfunction

  always_comb begin
    unique case (upc)
      // wait for start
      U_IDLE: uw = mk(ALU_ADD, SEL_RS, 5'd0, 1'b0, WB_NONE, SEL_TMP, 1'b0, 1'b0, 1'b0, 1'b0, SQ_WAIT, U_IDLE);
      // ALUOut <= count
      U_CNT:  uw = mk(ALU_ADD, SEL_RT, 5'd0, 1'b1, WB_NONE, SEL_TMP, 1'b0, 1'b0, 1'b0, 1'b0, SQ_NEXT, U_IDLE);
      // zero count exits; else ALUOut <= source pointer
      U_CHK:  uw = mk(ALU_ADD, SEL_RS, 5'd0, 1'b1, WB_NONE, SEL_TMP, 1'b0, 1'b0, 1'b0, 1'b0, SQ_BZ,   U_DONE);
      // issue read at ALUOut
      U_RD:   uw = mk(ALU_ADD, SEL_RS, 5'd0, 1'b0, WB_NONE, SEL_TMP, 1'b1, 1'b0, 1'b0, 1'b0, SQ_NEXT, U_IDLE);
      // MDR <= read data, ALUOut <= destination pointer
      U_CAP:  uw = mk(ALU_ADD, SEL_RD, 5'd0, 1'b1, WB_NONE, SEL_TMP, 1'b0, 1'b0, 1'b1, 1'b0, SQ_NEXT, U_IDLE);
      // scratch <= MDR
      U_SAV:  uw = mk(ALU_ADD, SEL_RS, 5'd0, 1'b0, WB_MDR,  SEL_TMP, 1'b0, 1'b0, 1'b0, 1'b0, SQ_NEXT, U_IDLE);
      // mem[ALUOut] <= scratch, ALUOut <= src + 4
      U_WR:   uw = mk(ALU_ADD, SEL_RS, 5'd4, 1'b1, WB_NONE, SEL_TMP, 1'b0, 1'b1, 1'b0, 1'b0, SQ_NEXT, U_IDLE);
      // src <= ALUOut, ALUOut <= dst + 4
      U_US:   uw = mk(ALU_ADD, SEL_RD, 5'd4, 1'b1, WB_ALU,  SEL_RS,  1'b0, 1'b0, 1'b0, 1'b0, SQ_NEXT, U_IDLE);
      // dst <= ALUOut, ALUOut <= count - 1
      U_UD:   uw = mk(ALU_SUB, SEL_RT, 5'd1, 1'b1, WB_ALU,  SEL_RD,  1'b0, 1'b0, 1'b0, 1'b0, SQ_NEXT, U_IDLE);
      // count <= ALUOut, ALUOut <= src; loop while old ALUOut nonzero
      U_UC:   uw = mk(ALU_ADD, SEL_RS, 5'd0, 1'b1, WB_ALU,  SEL_RT,  1'b0, 1'b0, 1'b0, 1'b0, SQ_BNZ,  U_RD);
      // completion pulse
      U_DONE: uw = mk(ALU_ADD, SEL_RS, 5'd0, 1'b0, WB_NONE, SEL_TMP, 1'b0, 1'b0, 1'b0, 1'b1, SQ_JMP,  U_IDLE);
      default: uw = mk(ALU_ADD, SEL_RS, 5'd0, 1'b0, WB_NONE, SEL_TMP, 1'b0, 1'b0, 1'b0, 1'b0, SQ_JMP, U_IDLE);
    endcase
  end
endmodule

// File: rtl/bcp_regfile.sv
module bcp_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [IW-1:0] ra_b,
  output logic [DW-1:0] rd_b,
  input  logic [IW-1:0] ra_c,
  output logic [DW-1:0] rd_c
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
  assign rd_c = regs[ra_c];
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import bcp_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int DW      = 32,
  parameter int TMP_REG = 8,
  localparam int IW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] rs_idx,
  input  logic [IW-1:0] rd_idx,
  input  logic [IW-1:0] rt_idx,
  output logic          busy,
  output logic          done,
  input  logic          ext_we,
  input  logic [IW-1:0] ext_idx,
  input  logic [DW-1:0] ext_wdata,
  output logic [DW-1:0] ext_rdata,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam logic [IW-1:0] TMP_IDX = IW'(TMP_REG);

  logic [UPC_W-1:0] upc, upc_nxt;
  uword_t           uw;
  logic [IW-1:0]    op_rs, op_rd, op_rt;
  logic [DW-1:0]    aluout, mdr, alu_a, alu_res, tmp_val;
  logic             rf_we;
  logic [IW-1:0]    rf_waddr, src_idx;
  logic [DW-1:0]    rf_wdata;

  // named internal events for the checker
  logic aluout_zero, br_taken, accept;

  function automatic logic [DW-1:0] alu_calc(alu_e op, logic [DW-1:0] a, logic [4:0] k);
    logic [DW-1:0] b;
    b = {{(DW-5){1'b0}}, k};
    return (op == ALU_SUB) ? a - b : a + b;
  endfunction

  function automatic logic [IW-1:0] pick(reg_sel_e s, logic [IW-1:0] i_rs,
                                         logic [IW-1:0] i_rd, logic [IW-1:0] i_rt);
    unique case (s)
      SEL_RS:  return i_rs;
      SEL_RD:  return i_rd;
      SEL_RT:  return i_rt;
      default: return TMP_IDX;
    endcase
  endfunction

  bcp_ucode_rom rom_i (.upc(upc), .uw(uw));

  assign busy        = (upc != U_IDLE);
  assign accept      = start && !busy;
  assign aluout_zero = (aluout == '0);
  assign br_taken    = ((uw.seq == SQ_BZ) && aluout_zero) ||
                       ((uw.seq == SQ_BNZ) && !aluout_zero);

  assign src_idx  = pick(uw.src1, op_rs, op_rd, op_rt);
  assign alu_res  = alu_calc(uw.op, alu_a, uw.imm);

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = ext_idx;
    rf_wdata = ext_wdata;
    if (!busy) begin
      rf_we = ext_we;
    end else if (uw.wb != WB_NONE) begin
      rf_we    = 1'b1;
      rf_waddr = pick(uw.dst, op_rs, op_rd, op_rt);
      rf_wdata = (uw.wb == WB_MDR) ? mdr : aluout;
    end
  end

  bcp_regfile #(.NREG(NREG), .DW(DW)) rf_i (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_a(src_idx), .rd_a(alu_a),
    .ra_b(TMP_IDX), .rd_b(tmp_val),
    .ra_c(ext_idx), .rd_c(ext_rdata)
  );

  always_comb begin
    unique case (uw.seq)
      SQ_WAIT: upc_nxt = accept ? U_CNT : U_IDLE;
      SQ_JMP:  upc_nxt = uw.tgt;
      SQ_BZ,
      SQ_BNZ:  upc_nxt = br_taken ? uw.tgt : UPC_W'(upc + 1'b1);
      default: upc_nxt = UPC_W'(upc + 1'b1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upc    <= U_IDLE;
      aluout <= '0;
      mdr    <= '0;
      op_rs  <= '0;
      op_rd  <= '0;
      op_rt  <= '0;
    end else begin
      upc <= upc_nxt;
      if (accept) begin
        op_rs <= rs_idx;
        op_rd <= rd_idx;
        op_rt <= rt_idx;
      end
      if (uw.ld_alu) aluout <= alu_res;
      if (uw.ld_mdr) mdr    <= mem_rdata;
    end
  end

  assign done      = uw.fin;
  assign mem_re    = uw.mrd;
  assign mem_we    = uw.mwr;
  assign mem_addr  = aluout;
  assign mem_wdata = tmp_val;
endmodule

// File: rtl/bcp_checker.sv
module bcp_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic mem_re,
  input logic mem_we,
  input logic aluout_zero,
  input logic br_taken
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !mem_we && !done));

  p_zero_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && aluout_zero) |=> done);

  p_loop_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !aluout_zero) |=> mem_re);

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_read_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (!mem_we && !mem_re));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_start_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind blkcopy_engine bcp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_re(mem_re), .mem_we(mem_we),
  .aluout_zero(aluout_zero), .br_taken(br_taken)
);

// File: tb/blkcopy_engine_tb_top.sv
`timescale 1ns/1ps
module blkcopy_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  rs_idx = '0, rd_idx = '0, rt_idx = '0;
  logic        busy, done;
  logic        ext_we = 1'b0;
  logic [4:0]  ext_idx = '0;
  logic [31:0] ext_wdata = '0;
  logic [31:0] ext_rdata;
  logic        mem_re, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];
  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, wr_seq_bad = 0;
  logic [31:0] wr_expect = '0;

  always #2 clk = ~clk;

  blkcopy_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rs_idx(rs_idx), .rd_idx(rd_idx), .rt_idx(rt_idx),
    .busy(busy), .done(done),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: registered read, write on the edge
  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= mem[mem_addr[9:2]];
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
      if (mem_addr != wr_expect) wr_seq_bad <= wr_seq_bad + 1;
      wr_expect <= wr_expect + 32'd4;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [4:0] idx, logic [31:0] val);
    @(negedge clk);
    ext_we = 1'b1; ext_idx = idx; ext_wdata = val;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  function automatic logic [31:0] reg_peek_dummy(logic [31:0] v);
    return v;
  endfunction

  task automatic reg_read(logic [4:0] idx, output logic [31:0] val);
    ext_idx = idx;
    #0.5;
    val = reg_peek_dummy(ext_rdata);
  endtask

  function automatic int latency(int n);
    return 2 + 7 * n;
  endfunction

  task automatic run_copy(int src, int dst, int n, logic [4:0] a, logic [4:0] b,
                          logic [4:0] c, bit disturb);
    logic [31:0] last, v;
    int cyc, diff;
    bit seen;
    reg_write(a, src * 4);
    reg_write(b, dst * 4);
    reg_write(c, n);
    reg_write(5'd8, 32'hDEAD_0001);
    last = 32'hDEAD_0001;
    for (int k = 0; k < n; k++) begin
      last = ref_mem[(src + k) % 256];
      ref_mem[(dst + k) % 256] = last;
    end
    rd_cnt = 0; wr_cnt = 0; wr_seq_bad = 0; wr_expect = dst * 4;
    @(negedge clk);
    start = 1'b1; rs_idx = a; rd_idx = b; rt_idx = c;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; seen = 0;
    while (!seen && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (disturb && cyc == 2) begin
        start = 1'b1; rs_idx = b; rd_idx = a; rt_idx = 5'd31;
        ext_we = 1'b1; ext_idx = c; ext_wdata = 32'd77;
      end else if (disturb && cyc == 3) begin
        start = 1'b0; ext_we = 1'b0;
      end
      if (done) seen = 1;
    end
    check("R2 latency", cyc, latency(n));
    @(negedge clk);
    check("R7 done cleared", {31'd0, done}, 32'd0);
    check("R7 idle after done", {31'd0, busy}, 32'd0);
    diff = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) diff++;
    check("R4 memory image", diff, 0);
    check("R6 read count", rd_cnt, n);
    check("R6 write count", wr_cnt, n);
    check("R6 write order", wr_seq_bad, 0);
    reg_read(a, v); check("R5 source reg", v, (src + n) * 4);
    reg_read(b, v); check("R5 dest reg", v, (dst + n) * 4);
    reg_read(c, v); check(disturb ? "R8 count reg" : "R5 count reg", v, 0);
    reg_read(5'd8, v); check("R5 scratch reg", v, last);
    if (n == 0) check("R3 zero count no access", rd_cnt + wr_cnt, 0);
  endtask

  initial begin
    bit finished;
    finished = 0;
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
          bad++; total++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = $urandom;
      ref_mem[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      logic [31:0] v;
      check("R1 busy", {31'd0, busy}, 0);
      check("R1 done", {31'd0, done}, 0);
      check("R1 mem idle", {30'd0, mem_re, mem_we}, 0);
      reg_read(5'd5, v); check("R1 register zero", v, 0);
    end
    // directed corners
    run_copy(10, 40, 0, 5'd1, 5'd9, 5'd20, 0);   // R3 zero length
    run_copy(20, 60, 1, 5'd2, 5'd10, 5'd21, 0);  // single word
    run_copy(100, 101, 5, 5'd3, 5'd11, 5'd22, 0); // R4 forward overlap
    run_copy(150, 180, 3, 5'd4, 5'd12, 5'd23, 1); // R8 start and write while busy
    // random mix
    for (int t = 0; t < 10; t++) begin
      run_copy($urandom % 200, $urandom % 200, $urandom % 7,
               5'(1 + $urandom % 7), 5'(9 + $urandom % 10), 5'(19 + $urandom % 12), 0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule